// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block raises DMA handshake requests for the transmit and receive FIFOs of a UART. A small control register holds a receive enable, a transmit enable and a mask-on-error bit. The block compares each FIFO's occupancy against a programmable watermark. For each direction it drives two request lines. The single line asks for one 8-bit character. The burst line asks for one watermark's worth of characters.

A DMA controller that takes a burst whenever one is offered, and a single otherwise, moves most of a stream in whole bursts. The tail that is shorter than the watermark then goes by single transfers. After each transfer the controller pulses a clear input, which drops both request lines of that direction for one cycle. The lines are then worked out again from the updated FIFO level.

While the mask-on-error bit is set, an active UART error interrupt holds both receive request lines low. The transmit side is not affected by the error interrupt.

Top module: `uart_dma_req`

## Requirements
- R1: After reset the control register reads 0 and all four request outputs are low.
- R2: The control register sits at byte offset 0x48: bit 0 is receive enable, bit 1 is transmit enable, bit 2 is mask-on-error, and bits 31:3 read as 0. A write to any other offset leaves the register unchanged. A read at any other offset returns 0.
- R3: The request outputs are registered and follow their inputs one clock later. With receive enabled, the receive single request is high when the receive level is at least 1.
- R4: With receive enabled, the receive burst request is high when the receive level is at or above the effective receive watermark.
- R5: The transmit free space is DEPTH minus the transmit level. With transmit enabled, the transmit single request is high when the free space is at least 1. The transmit burst request is high when the free space is at or above the effective transmit watermark.
- R6: When the enable bit of a direction is 0, both request outputs of that direction are low.
- R7: When mask-on-error is 1 and the error interrupt is high, both receive requests are low and the transmit requests are unaffected. When mask-on-error is 0, the error interrupt has no effect.
- R8: A one-cycle clear pulse for a direction makes both of its request outputs low in the next cycle, and leaves the other direction unaffected. One cycle later the outputs again reflect the FIFO level.
- R9: A watermark of 0 acts as 1, and a watermark above DEPTH acts as DEPTH.
- R10: A greedy controller that moves N characters with watermark W sees exactly N/W bursts (integer division) and N mod W singles. For example, 19 characters with W=4 give four bursts and three singles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| rx_level | input | 5 | Characters held in the receive FIFO |
| tx_level | input | 5 | Characters held in the transmit FIFO |
| rx_wmark | input | 5 | Receive watermark |
| tx_wmark | input | 5 | Transmit watermark |
| err_irq | input | 1 | UART error interrupt |
| rx_clr | input | 1 | Receive transfer done / clear from the DMA controller |
| tx_clr | input | 1 | Transmit transfer done / clear from the DMA controller |
| rx_sreq | output | 1 | Receive single request |
| rx_breq | output | 1 | Receive burst request |
| tx_sreq | output | 1 | Transmit single request |
| tx_breq | output | 1 | Transmit burst request |

## Verification
The bench uses the default parameters: a FIFO depth of 16, which gives 5-bit level and watermark ports, and the control register at offset 0x48. With a depth of 16, a 19-character stream exceeds the FIFO, so the modelled receiver has to refill the FIFO while bursts drain it. The 5-bit watermark port can carry values up to 31, which makes the zero and above-depth saturation cases reachable. Stream lengths that are exact multiples of the watermark, shorter than it, and a watermark equal to the full depth all exercise the burst/single split.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

  // Control word; bit 0 = rx_en, bit 1 = tx_en, bit 2 = on_err
  typedef struct packed {
    logic on_err;
    logic tx_en;
    logic rx_en;
  } ctrl_t;

  localparam int CTRL_W      = $bits(ctrl_t);
  localparam int LANE_RX     = 0;
  localparam int LANE_TX     = 1;
  localparam int NUM_LANES   = 2;

endpackage

// File: rtl/uart_dma_csr.sv
module uart_dma_csr
  import uart_dma_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [7:0]  CTRL_OFS = 8'h48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl
);

  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CTRL_OFS);

  logic  hit;
  logic  ctrl_we;
  ctrl_t ctrl_d;
  ctrl_t ctrl_q;

  always_comb begin
    hit     = (addr == OFS);
    ctrl_we = wr & hit;
    ctrl_d  = ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata[CTRL_W-1:0] = ctrl_q;
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/uart_dma_lane.sv
module uart_dma_lane #(
  parameter int DEPTH = 16,
  parameter bit IS_TX = 1'b0,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          gate,
  input  logic          clr,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] wmark,
  output logic          sreq,
  output logic          breq
);

  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  logic [LW-1:0] wm_eff;
  logic [LW-1:0] avail;
  logic          live;
  logic          sreq_d, breq_d;
  logic          sreq_q, breq_q;

  // Saturate watermark into 1..DEPTH
  always_comb begin
    if (wmark == '0)          wm_eff = LW'(1);
    else if (wmark > DEPTH_L) wm_eff = DEPTH_L;
    else                      wm_eff = wmark;
  end

  // Characters that can move: held data (rx) or free slots (tx)
  generate
    if (IS_TX) begin : g_tx
      assign avail = DEPTH_L - level;
    end else begin : g_rx
      assign avail = level;
    end
  endgenerate

  always_comb begin
    live   = enable & ~gate & ~clr;
    sreq_d = live & (avail != '0);
    breq_d = live & (avail >= wm_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreq_q <= 1'b0;
      breq_q <= 1'b0;
    end else begin
      sreq_q <= sreq_d;
      breq_q <= breq_d;
    end
  end

  assign sreq = sreq_q;
  assign breq = breq_q;

endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
  import uart_dma_pkg::*;
#(
  parameter int         DEPTH    = 16,
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 32,
  parameter logic [7:0] CTRL_OFS = 8'h48,
  localparam int        LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_wmark,
  input  logic [LVL_W-1:0]  tx_wmark,
  input  logic              err_irq,
  input  logic              rx_clr,
  input  logic              tx_clr,
  output logic              rx_sreq,
  output logic              rx_breq,
  output logic              tx_sreq,
  output logic              tx_breq
);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  ctrl_t ctrl_q;

  uart_dma_csr #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CTRL_OFS(CTRL_OFS)
  ) i_csr (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .wr   (reg_wr),
    .addr (reg_addr),
    .wdata(reg_wdata),
    .rdata(reg_rdata),
    .ctrl (ctrl_q)
  );

  logic [LVL_W-1:0] lane_lvl [NUM_LANES];
  logic [LVL_W-1:0] lane_wm  [NUM_LANES];
  logic             lane_en  [NUM_LANES];
  logic             lane_gt  [NUM_LANES];
  logic             lane_clr [NUM_LANES];
  logic             lane_s   [NUM_LANES];
  logic             lane_b   [NUM_LANES];

  always_comb begin
    lane_lvl[LANE_RX] = rx_level;
    lane_lvl[LANE_TX] = tx_level;
    lane_wm[LANE_RX]  = rx_wmark;
    lane_wm[LANE_TX]  = tx_wmark;
    lane_en[LANE_RX]  = ctrl_q.rx_en;
    lane_en[LANE_TX]  = ctrl_q.tx_en;
    lane_gt[LANE_RX]  = ctrl_q.on_err & err_irq;
    lane_gt[LANE_TX]  = 1'b0;
    lane_clr[LANE_RX] = rx_clr;
    lane_clr[LANE_TX] = tx_clr;
  end

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      uart_dma_lane #(
        .DEPTH(DEPTH),
        .IS_TX(g == LANE_TX)
      ) i_lane (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .enable(lane_en[g]),
        .gate  (lane_gt[g]),
        .clr   (lane_clr[g]),
        .level (lane_lvl[g]),
        .wmark (lane_wm[g]),
        .sreq  (lane_s[g]),
        .breq  (lane_b[g])
      );
    end
  endgenerate

  assign rx_sreq = lane_s[LANE_RX];
  assign rx_breq = lane_b[LANE_RX];
  assign tx_sreq = lane_s[LANE_TX];
  assign tx_breq = lane_b[LANE_TX];

endmodule

// File: rtl/uart_dma_chk.sv
module uart_dma_chk
  import uart_dma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input ctrl_t             ctrl,
  input logic              err_irq,
  input logic              rx_clr,
  input logic              tx_clr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              rx_sreq,
  input logic              rx_breq,
  input logic              tx_sreq,
  input logic              tx_breq
);

  // R6
  rx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.rx_en |=> (!rx_sreq && !rx_breq));

  // R6
  tx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.tx_en |=> (!tx_sreq && !tx_breq));

  // R7
  err_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.on_err && err_irq) |=> (!rx_sreq && !rx_breq));

  // R8
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (!rx_sreq && !rx_breq));

  // R8
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> (!tx_sreq && !tx_breq));

  // R4
  rx_burst_has_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_breq |-> rx_sreq);

  // R5
  tx_burst_has_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_breq |-> tx_sreq);

  // R2
  always_comb begin
    if (rst_n) begin
      upper_zero_chk: assert (reg_rdata[DATA_W-1:CTRL_W] == '0);
    end
  end

endmodule

bind uart_dma_req uart_dma_chk #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .ctrl     (ctrl_q),
  .err_irq  (err_irq),
  .rx_clr   (rx_clr),
  .tx_clr   (tx_clr),
  .reg_rdata(reg_rdata),
  .rx_sreq  (rx_sreq),
  .rx_breq  (rx_breq),
  .tx_sreq  (tx_sreq),
  .tx_breq  (tx_breq)
);

// File: tb/test_uart_dma_req.sv
module test_uart_dma_req;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int LW         = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [LW-1:0] rx_level, tx_level, rx_wmark, tx_wmark;
  logic          err_irq, rx_clr, tx_clr;
  logic          rx_sreq, rx_breq, tx_sreq, tx_breq;

  int n_chk  = 0;
  int n_err  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_dma_req #(.DEPTH(DEPTH)) i_uart_dma_req (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_level(rx_level), .tx_level(tx_level), .rx_wmark(rx_wmark), .tx_wmark(tx_wmark),
    .err_irq(err_irq), .rx_clr(rx_clr), .tx_clr(tx_clr),
    .rx_sreq(rx_sreq), .rx_breq(rx_breq), .tx_sreq(tx_sreq), .tx_breq(tx_breq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h48;
    @(negedge clk);
  endtask

  task automatic set_in(input int rl, input int rw, input int tl, input int tw);
    rx_level = LW'(rl); rx_wmark = LW'(rw);
    tx_level = LW'(tl); tx_wmark = LW'(tw);
    @(negedge clk);
  endtask

  task automatic t_reset;
    reg_addr = 8'h48;
    chk("R1 ctrl", int'(reg_rdata), 0);
    chk("R1 reqs", int'({rx_sreq, rx_breq, tx_sreq, tx_breq}), 0);
  endtask

  task automatic t_regs;
    wr_ctrl(8'h48, 32'hFFFF_FFFF);
    chk("R2 readback masked", int'(reg_rdata), 7);
    wr_ctrl(8'h44, 32'h0);
    chk("R2 other offset ignored", int'(reg_rdata), 7);
    reg_addr = 8'h44; #1;
    chk("R2 other offset reads 0", int'(reg_rdata), 0);
    reg_addr = 8'h48;
    wr_ctrl(8'h48, 32'h3);
    chk("R2 write 3", int'(reg_rdata), 3);
  endtask

  task automatic t_rx_levels;
    set_in(0, 4, 16, 4);
    chk("R3 rx empty single", int'(rx_sreq), 0);
    set_in(1, 4, 16, 4);
    chk("R3 rx one single", int'(rx_sreq), 1);
    chk("R4 rx one burst", int'(rx_breq), 0);
    set_in(3, 4, 16, 4);
    chk("R4 rx below wm", int'(rx_breq), 0);
    set_in(4, 4, 16, 4);
    chk("R4 rx at wm", int'(rx_breq), 1);
  endtask

  task automatic t_tx_levels;
    set_in(0, 4, 16, 4);
    chk("R5 tx full single", int'(tx_sreq), 0);
    set_in(0, 4, 15, 4);
    chk("R5 tx one free single", int'(tx_sreq), 1);
    chk("R5 tx one free burst", int'(tx_breq), 0);
    set_in(0, 4, 12, 4);
    chk("R5 tx free at wm", int'(tx_breq), 1);
    set_in(0, 4, 13, 4);
    chk("R5 tx free below wm", int'(tx_breq), 0);
  endtask

  task automatic t_enable;
    wr_ctrl(8'h48, 32'h2);
    set_in(8, 4, 0, 4);
    chk("R6 rx disabled", int'({rx_sreq, rx_breq}), 0);
    chk("R6 tx enabled", int'({tx_sreq, tx_breq}), 3);
    wr_ctrl(8'h48, 32'h1);
    chk("R6 tx disabled", int'({tx_sreq, tx_breq}), 0);
    chk("R6 rx enabled", int'({rx_sreq, rx_breq}), 3);
  endtask

  task automatic t_error;
    wr_ctrl(8'h48, 32'h7);
    set_in(5, 4, 0, 4);
    err_irq = 1'b1; @(negedge clk);
    chk("R7 rx masked", int'({rx_sreq, rx_breq}), 0);
    chk("R7 tx unaffected", int'({tx_sreq, tx_breq}), 3);
    err_irq = 1'b0; @(negedge clk);
    chk("R7 rx restored", int'({rx_sreq, rx_breq}), 3);
    wr_ctrl(8'h48, 32'h3);
    err_irq = 1'b1; @(negedge clk);
    chk("R7 no mask when off", int'({rx_sreq, rx_breq}), 3);
    err_irq = 1'b0;
  endtask

  task automatic t_clear;
    set_in(5, 4, 0, 4);
    rx_clr = 1'b1; @(negedge clk); rx_clr = 1'b0;
    chk("R8 rx cleared", int'({rx_sreq, rx_breq}), 0);
    chk("R8 tx unaffected by rx clr", int'({tx_sreq, tx_breq}), 3);
    @(negedge clk);
    chk("R8 rx re-evaluated", int'({rx_sreq, rx_breq}), 3);
    tx_clr = 1'b1; @(negedge clk); tx_clr = 1'b0;
    chk("R8 tx cleared", int'({tx_sreq, tx_breq}), 0);
    @(negedge clk);
    chk("R8 tx re-evaluated", int'({tx_sreq, tx_breq}), 3);
  endtask

  task automatic t_wmark;
    set_in(1, 0, 16, 0);
    chk("R9 rx wm0 as 1", int'(rx_breq), 1);
    set_in(15, 31, 16, 0);
    chk("R9 rx wm31 level15", int'(rx_breq), 0);
    set_in(16, 31, 0, 31);
    chk("R9 rx wm31 level16", int'(rx_breq), 1);
    chk("R9 tx wm31 free16", int'(tx_breq), 1);
  endtask

  task automatic t_rx_stream(input int n, input int w);
    int lvl = 0, arrived = 0, moved = 0, nb = 0, ns = 0, guard = 0;
    rx_wmark = LW'(w);
    while (moved < n && guard < 200) begin
      int push;
      guard++;
      push = DEPTH - lvl;
      if (push > n - arrived) push = n - arrived;
      lvl += push; arrived += push;
      rx_level = LW'(lvl);
      @(negedge clk);
      if (rx_breq) begin lvl -= w; moved += w; nb++; end
      else if (rx_sreq) begin lvl -= 1; moved += 1; ns++; end
      rx_level = LW'(lvl);
      rx_clr = 1'b1; @(negedge clk); rx_clr = 1'b0;
    end
    chk($sformatf("R10 rx n=%0d w=%0d bursts", n, w), nb, n / w);
    chk($sformatf("R10 rx n=%0d w=%0d singles", n, w), ns, n % w);
  endtask

  task automatic t_tx_stream(input int n, input int w);
    int rem = n, nb = 0, ns = 0, guard = 0;
    tx_wmark = LW'(w);
    while (rem > 0 && guard < 200) begin
      guard++;
      tx_level = '0;
      @(negedge clk);
      if (rem >= w && tx_breq) begin rem -= w; nb++; tx_level = LW'(w); end
      else if (tx_sreq) begin rem -= 1; ns++; tx_level = LW'(1); end
      tx_clr = 1'b1; @(negedge clk); tx_clr = 1'b0;
    end
    chk($sformatf("R10 tx n=%0d w=%0d bursts", n, w), nb, n / w);
    chk($sformatf("R10 tx n=%0d w=%0d singles", n, w), ns, n % w);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h48; reg_wdata = '0;
    rx_level = '0; tx_level = '0; rx_wmark = LW'(4); tx_wmark = LW'(4);
    err_irq = 1'b0; rx_clr = 1'b0; tx_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_regs;
    t_rx_levels;
    t_tx_levels;
    t_enable;
    t_error;
    t_clear;
    t_wmark;
    wr_ctrl(8'h48, 32'h3);
    t_rx_stream(19, 4);
    t_rx_stream(16, 4);
    t_rx_stream(7, 3);
    t_rx_stream(5, 8);
    t_rx_stream(20, 16);
    t_tx_stream(19, 4);
    t_tx_stream(10, 3);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_err++;
          $display("FAIL watchdog: actual=timeout expected=completion");
        end
      end
      wait (done);
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule